// File: doc/BRIEF.md
# Pipeline Operand and Store-Data Bypass Selector

This block chooses where each operand of a five-stage pipeline comes from. The instruction in the execute stage has two source register indices. The unit compares them with the destination indices of the two older instructions that have not yet written back. The first of these sits in the EX/MEM register and the second in the MEM/WB register. For each operand the unit returns a 2-bit select code that steers the execute-stage input mux. The unit also checks a store in the memory stage. The store's data-source index is carried down from execute, and it is compared against the writeback destination. On a match, a one-bit select swaps in the writeback value for the store data.

The logic is purely combinational, so ALU results one or two instructions old reach their consumer with no lost cycle. A parameter adds the datapath muxes, so the block also delivers the forwarded operand values and the store data. When the muxes are left out, the value outputs carry the register-file values and the stale store data, and only the select codes are meaningful. A flag marks a load held in EX/MEM, and that load is never offered as a bypass source, because its data does not exist yet.

Top module: `fwd_unit`

## Requirements
- R1: Each operand select is 2 bits wide, with three legal codes. 2'b10 selects the EX/MEM ALU result, 2'b01 selects the MEM/WB writeback value, and 2'b00 selects the register-file value. The code 2'b11 never appears.
- R2: A producer matches a source only under three conditions. Its write enable must be 1, its destination index must be nonzero, and that index must equal the source index. A producer writing register 0, or one with write enable 0, never causes a bypass.
- R3: If both the EX/MEM producer and the MEM/WB producer match the same source, the select is 2'b10, because the EX/MEM result is newer.
- R4: The select for operand A (from ex_rs1) and the select for operand B (from ex_rs2) are computed independently. In one cycle, one operand can be 2'b10 while the other is 2'b01.
- R5: When exmem_is_load is 1, the EX/MEM producer is not a bypass source. The select then falls to 2'b01 if MEM/WB matches, and to 2'b00 otherwise.
- R6: st_sel is 1 only under three conditions: memwb_wen is 1, memwb_rd is nonzero, and memwb_rd equals mem_st_rs2. When st_sel is 1, st_data equals memwb_wdata. When st_sel is 0, st_data equals mem_st_data.
- R7: With FWD_DATA=1, op_a and op_b carry the value named by their select code, in the same cycle as the inputs change.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| ex_rs1 | input | RAW | Source index A of the instruction in execute |
| ex_rs2 | input | RAW | Source index B of the instruction in execute |
| exmem_rd | input | RAW | Destination index held in EX/MEM |
| exmem_wen | input | 1 | Register write enable held in EX/MEM |
| exmem_is_load | input | 1 | EX/MEM instruction is a load |
| memwb_rd | input | RAW | Destination index held in MEM/WB |
| memwb_wen | input | 1 | Register write enable held in MEM/WB |
| mem_st_rs2 | input | RAW | Store data-source index carried into MEM |
| rf_a | input | XLEN | Register-file value for operand A |
| rf_b | input | XLEN | Register-file value for operand B |
| exmem_alu | input | XLEN | ALU result held in EX/MEM |
| memwb_wdata | input | XLEN | Final writeback value (load data or ALU result) |
| mem_st_data | input | XLEN | Store data carried into MEM |
| sel_a | output | 2 | Operand A source code |
| sel_b | output | 2 | Operand B source code |
| st_sel | output | 1 | Store-data replacement select |
| op_a | output | XLEN | Forwarded operand A |
| op_b | output | XLEN | Forwarded operand B |
| st_data | output | XLEN | Store data after forwarding |

## Verification
The bench targets several corner cases, each with a distinct failure mode.

- Both producers naming the same source. A design with the priority reversed returns the older MEM/WB value.
- A producer writing register 0. A design that skips the zero test forwards a value into a register that is hard-wired to zero.
- A producer with write enable low. A design that skips the enable test forwards from instructions that never write.
- A load in EX/MEM. A design that ignores the load flag selects an ALU result that is really an address.
- Both operands active in one cycle, one matching EX/MEM and the other matching MEM/WB. A design that shares one decision between operands gets one of them wrong.
- The store path. An off-by-one compare, or a compare against the wrong index, either feeds stale store data or overwrites correct store data.

// File: rtl/fwd_pkg.sv
package fwd_pkg;

  typedef enum logic [1:0] {
    SRC_RF    = 2'b00,
    SRC_MEMWB = 2'b01,
    SRC_EXMEM = 2'b10
  } op_src_e;

  // Newer producer first.
  function automatic op_src_e pick_src(input logic newer_hit, input logic older_hit);
    if (newer_hit)      return SRC_EXMEM;
    else if (older_hit) return SRC_MEMWB;
    else                return SRC_RF;
  endfunction

endpackage

// File: rtl/fwd_match.sv
module fwd_match #(
  parameter int RAW = 5
) (
  input  logic           wen,
  input  logic [RAW-1:0] dst,
  input  logic [RAW-1:0] src,
  output logic           hit
);
  localparam logic [RAW-1:0] ZERO_REG = '0;

  assign hit = wen && (dst != ZERO_REG) && (dst == src);

  always_comb begin
    p_no_zero_hit_r2: assert (!(hit && dst == ZERO_REG))
      else $error("register 0 produced a match");
  end
endmodule

// File: rtl/fwd_op_sel.sv
module fwd_op_sel
  import fwd_pkg::*;
#(
  parameter int RAW = 5
) (
  input  logic [RAW-1:0] src,
  input  logic [RAW-1:0] exmem_rd,
  input  logic           exmem_wen,
  input  logic           exmem_is_load,
  input  logic [RAW-1:0] memwb_rd,
  input  logic           memwb_wen,
  output op_src_e        sel,
  output logic           newer_hit,
  output logic           older_hit
);
  logic exmem_usable;

  assign exmem_usable = exmem_wen && !exmem_is_load;

  fwd_match #(.RAW(RAW)) u_newer (
    .wen(exmem_usable), .dst(exmem_rd), .src(src), .hit(newer_hit)
  );
  fwd_match #(.RAW(RAW)) u_older (
    .wen(memwb_wen), .dst(memwb_rd), .src(src), .hit(older_hit)
  );

  assign sel = pick_src(newer_hit, older_hit);

  always_comb begin
    p_newer_wins_r3: assert (!(newer_hit && older_hit) || sel == SRC_EXMEM)
      else $error("older producer won over newer");
    p_load_not_src_r5: assert (!exmem_is_load || sel != SRC_EXMEM)
      else $error("load in EX/MEM used as bypass source");
  end
endmodule

// File: rtl/fwd_st_sel.sv
module fwd_st_sel #(
  parameter int RAW = 5
) (
  input  logic [RAW-1:0] st_rs2,
  input  logic [RAW-1:0] memwb_rd,
  input  logic           memwb_wen,
  output logic           st_sel
);
  fwd_match #(.RAW(RAW)) u_st (
    .wen(memwb_wen), .dst(memwb_rd), .src(st_rs2), .hit(st_sel)
  );

  always_comb begin
    p_st_needs_wen_r6: assert (!st_sel || memwb_wen)
      else $error("store bypass without write enable");
  end
endmodule

// File: rtl/fwd_unit.sv
module fwd_unit
  import fwd_pkg::*;
#(
  parameter int RAW      = 5,
  parameter int XLEN     = 32,
  parameter bit FWD_DATA = 1'b1
) (
  input  logic [RAW-1:0]  ex_rs1,
  input  logic [RAW-1:0]  ex_rs2,
  input  logic [RAW-1:0]  exmem_rd,
  input  logic            exmem_wen,
  input  logic            exmem_is_load,
  input  logic [RAW-1:0]  memwb_rd,
  input  logic            memwb_wen,
  input  logic [RAW-1:0]  mem_st_rs2,
  input  logic [XLEN-1:0] rf_a,
  input  logic [XLEN-1:0] rf_b,
  input  logic [XLEN-1:0] exmem_alu,
  input  logic [XLEN-1:0] memwb_wdata,
  input  logic [XLEN-1:0] mem_st_data,
  output logic [1:0]      sel_a,
  output logic [1:0]      sel_b,
  output logic            st_sel,
  output logic [XLEN-1:0] op_a,
  output logic [XLEN-1:0] op_b,
  output logic [XLEN-1:0] st_data
);
  localparam int NUM_OPS = 2;

  logic [NUM_OPS-1:0][RAW-1:0]  op_src_idx;
  logic [NUM_OPS-1:0][XLEN-1:0] op_rf_val;
  logic [NUM_OPS-1:0][XLEN-1:0] op_out_val;
  op_src_e                      op_sel [NUM_OPS];
  logic [NUM_OPS-1:0]           op_newer_hit;
  logic [NUM_OPS-1:0]           op_older_hit;

  assign op_src_idx[0] = ex_rs1;
  assign op_src_idx[1] = ex_rs2;
  assign op_rf_val[0]  = rf_a;
  assign op_rf_val[1]  = rf_b;

  function automatic logic [XLEN-1:0] mux3(input op_src_e s, input logic [XLEN-1:0] rf,
                                           input logic [XLEN-1:0] newer,
                                           input logic [XLEN-1:0] older);
    case (s)
      SRC_EXMEM: return newer;
      SRC_MEMWB: return older;
      default:   return rf;
    endcase
  endfunction

  for (genvar g = 0; g < NUM_OPS; g++) begin : g_op
    fwd_op_sel #(.RAW(RAW)) u_sel (
      .src          (op_src_idx[g]),
      .exmem_rd     (exmem_rd),
      .exmem_wen    (exmem_wen),
      .exmem_is_load(exmem_is_load),
      .memwb_rd     (memwb_rd),
      .memwb_wen    (memwb_wen),
      .sel          (op_sel[g]),
      .newer_hit    (op_newer_hit[g]),
      .older_hit    (op_older_hit[g])
    );

    if (FWD_DATA) begin : g_mux
      assign op_out_val[g] = mux3(op_sel[g], op_rf_val[g], exmem_alu, memwb_wdata);
    end else begin : g_nomux
      assign op_out_val[g] = op_rf_val[g];
    end
  end

  fwd_st_sel #(.RAW(RAW)) u_st (
    .st_rs2   (mem_st_rs2),
    .memwb_rd (memwb_rd),
    .memwb_wen(memwb_wen),
    .st_sel   (st_sel)
  );

  assign sel_a = op_sel[0];
  assign sel_b = op_sel[1];
  assign op_a  = op_out_val[0];
  assign op_b  = op_out_val[1];

  if (FWD_DATA) begin : g_st_mux
    assign st_data = st_sel ? memwb_wdata : mem_st_data;
  end else begin : g_st_nomux
    assign st_data = mem_st_data;
  end

  always_comb begin
    p_legal_code_a_r1: assert (sel_a != 2'b11) else $error("illegal sel_a");
    p_legal_code_b_r1: assert (sel_b != 2'b11) else $error("illegal sel_b");
    p_exmem_cond_r2: assert (sel_a != 2'b10 ||
                             (exmem_wen && exmem_rd != '0 && exmem_rd == ex_rs1))
      else $error("EX/MEM bypass without full match");
    p_memwb_cond_r2: assert (sel_b != 2'b01 ||
                             (memwb_wen && memwb_rd != '0 && memwb_rd == ex_rs2))
      else $error("MEM/WB bypass without full match");
    if (FWD_DATA) begin
      p_opa_value_r7: assert (sel_a != 2'b10 || op_a == exmem_alu)
        else $error("op_a not EX/MEM value");
      p_opb_value_r7: assert (sel_b != 2'b01 || op_b == memwb_wdata)
        else $error("op_b not MEM/WB value");
      p_st_value_r6: assert (!st_sel || st_data == memwb_wdata)
        else $error("store data not replaced");
    end
  end
endmodule

// File: tb/fwd_unit_tb.sv
module fwd_unit_tb;
  localparam int RAW  = 5;
  localparam int XLEN = 32;

  logic clk = 1'b0;
  always #5 clk = ~clk;

  logic [RAW-1:0]  ex_rs1, ex_rs2, exmem_rd, memwb_rd, mem_st_rs2;
  logic            exmem_wen, exmem_is_load, memwb_wen;
  logic [XLEN-1:0] rf_a, rf_b, exmem_alu, memwb_wdata, mem_st_data;
  logic [1:0]      sel_a, sel_b;
  logic            st_sel;
  logic [XLEN-1:0] op_a, op_b, st_data;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  fwd_unit #(.RAW(RAW), .XLEN(XLEN), .FWD_DATA(1'b1)) u_dut (
    .ex_rs1, .ex_rs2, .exmem_rd, .exmem_wen, .exmem_is_load, .memwb_rd,
    .memwb_wen, .mem_st_rs2, .rf_a, .rf_b, .exmem_alu, .memwb_wdata,
    .mem_st_data, .sel_a, .sel_b, .st_sel, .op_a, .op_b, .st_data
  );

  // Independent model: returns code for one source.
  function automatic logic [1:0] exp_code(input logic [RAW-1:0] s);
    logic ex_ok, wb_ok;
    ex_ok = (s != 0) && exmem_wen && !exmem_is_load && (exmem_rd == s);
    wb_ok = (s != 0) && memwb_wen && (memwb_rd == s);
    case ({ex_ok, wb_ok})
      2'b10, 2'b11: return 2'b10;
      2'b01:        return 2'b01;
      default:      return 2'b00;
    endcase
  endfunction

  function automatic logic [XLEN-1:0] exp_val(input logic [1:0] c, input logic [XLEN-1:0] rf);
    return (c == 2'b10) ? exmem_alu : (c == 2'b01) ? memwb_wdata : rf;
  endfunction

  task automatic chk(input string req, input string what, input logic [XLEN-1:0] act,
                     input logic [XLEN-1:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic check_all(input string req);
    logic [1:0] ea, eb;
    logic       es;
    ea = exp_code(ex_rs1);
    eb = exp_code(ex_rs2);
    es = memwb_wen && (memwb_rd != 0) && (memwb_rd == mem_st_rs2);
    chk(req, "sel_a", {30'd0, sel_a}, {30'd0, ea});
    chk(req, "sel_b", {30'd0, sel_b}, {30'd0, eb});
    chk(req, "op_a", op_a, exp_val(ea, rf_a));
    chk(req, "op_b", op_b, exp_val(eb, rf_b));
    chk(req, "st_sel", {31'd0, st_sel}, {31'd0, es});
    chk(req, "st_data", st_data, es ? memwb_wdata : mem_st_data);
  endtask

  task automatic apply(input logic [RAW-1:0] r1, input logic [RAW-1:0] r2,
                       input logic [RAW-1:0] erd, input logic ew, input logic eld,
                       input logic [RAW-1:0] wrd, input logic ww, input logic [RAW-1:0] srs);
    @(negedge clk);
    ex_rs1 = r1; ex_rs2 = r2; exmem_rd = erd; exmem_wen = ew; exmem_is_load = eld;
    memwb_rd = wrd; memwb_wen = ww; mem_st_rs2 = srs;
    #2;
  endtask

  task automatic t_idle();
    apply(0, 0, 0, 0, 0, 0, 0, 0);
    chk("R1", "idle sel_a", {30'd0, sel_a}, 32'd0);
    chk("R1", "idle st_sel", {31'd0, st_sel}, 32'd0);
    check_all("R1");
  endtask

  task automatic t_exmem_fwd();
    apply(5'd3, 5'd9, 5'd3, 1, 0, 5'd7, 1, 5'd0);
    chk("R1", "EX/MEM code", {30'd0, sel_a}, 32'd2);
    chk("R7", "EX/MEM value", op_a, exmem_alu);
    check_all("R7");
  endtask

  task automatic t_memwb_fwd();
    apply(5'd4, 5'd12, 5'd1, 1, 0, 5'd12, 1, 5'd0);
    chk("R1", "MEM/WB code", {30'd0, sel_b}, 32'd1);
    chk("R7", "MEM/WB value", op_b, memwb_wdata);
    check_all("R7");
  endtask

  task automatic t_priority();
    apply(5'd6, 5'd6, 5'd6, 1, 0, 5'd6, 1, 5'd0);
    chk("R3", "both match A", {30'd0, sel_a}, 32'd2);
    chk("R3", "both match B", op_b, exmem_alu);
    check_all("R3");
  endtask

  task automatic t_reg_zero();
    apply(5'd0, 5'd0, 5'd0, 1, 0, 5'd0, 1, 5'd0);
    chk("R2", "x0 not forwarded A", {30'd0, sel_a}, 32'd0);
    chk("R2", "x0 not forwarded store", {31'd0, st_sel}, 32'd0);
    check_all("R2");
  endtask

  task automatic t_wen_off();
    apply(5'd8, 5'd8, 5'd8, 0, 0, 5'd8, 0, 5'd8);
    chk("R2", "wen off A", op_a, rf_a);
    chk("R2", "wen off B", {30'd0, sel_b}, 32'd0);
    check_all("R2");
    apply(5'd8, 5'd9, 5'd9, 1, 0, 5'd10, 1, 5'd11);
    chk("R2", "index mismatch A", {30'd0, sel_a}, 32'd0);
    check_all("R2");
  endtask

  task automatic t_split();
    apply(5'd14, 5'd21, 5'd14, 1, 0, 5'd21, 1, 5'd0);
    chk("R4", "split A", {30'd0, sel_a}, 32'd2);
    chk("R4", "split B", {30'd0, sel_b}, 32'd1);
    check_all("R4");
    apply(5'd21, 5'd14, 5'd14, 1, 0, 5'd21, 1, 5'd0);
    chk("R4", "swapped A", {30'd0, sel_a}, 32'd1);
    chk("R4", "swapped B", {30'd0, sel_b}, 32'd2);
  endtask

  task automatic t_load();
    apply(5'd2, 5'd2, 5'd2, 1, 1, 5'd2, 1, 5'd0);
    chk("R5", "load falls to MEM/WB", {30'd0, sel_a}, 32'd1);
    apply(5'd2, 5'd2, 5'd2, 1, 1, 5'd5, 1, 5'd0);
    chk("R5", "load falls to RF", {30'd0, sel_a}, 32'd0);
    chk("R5", "load falls to RF value", op_b, rf_b);
    check_all("R5");
  endtask

  task automatic t_store();
    apply(5'd0, 5'd0, 5'd0, 0, 0, 5'd17, 1, 5'd17);
    chk("R6", "store replaced sel", {31'd0, st_sel}, 32'd1);
    chk("R6", "store replaced data", st_data, memwb_wdata);
    apply(5'd0, 5'd0, 5'd0, 0, 0, 5'd17, 1, 5'd16);
    chk("R6", "store kept", st_data, mem_st_data);
    apply(5'd0, 5'd0, 5'd0, 0, 0, 5'd17, 0, 5'd17);
    chk("R6", "store wen off", st_data, mem_st_data);
    apply(5'd0, 5'd0, 5'd17, 1, 0, 5'd0, 1, 5'd0);
    chk("R6", "store x0", {31'd0, st_sel}, 32'd0);
    check_all("R6");
  endtask

  task automatic t_sweep();
    for (int i = 0; i < 64; i++) begin
      apply(i[4:0], i[5:1], 5'(i % 7), i[0], i[3], 5'(i % 5), i[1], i[4:0]);
      check_all("R7");
    end
  endtask

  initial begin
    ex_rs1 = 0; ex_rs2 = 0; exmem_rd = 0; memwb_rd = 0; mem_st_rs2 = 0;
    exmem_wen = 0; exmem_is_load = 0; memwb_wen = 0;
    rf_a = 32'hA0A0_0001; rf_b = 32'hB0B0_0002; exmem_alu = 32'hE0E0_0003;
    memwb_wdata = 32'hD0D0_0004; mem_st_data = 32'h5555_0005;
    t_idle();
    t_exmem_fwd();
    t_memwb_fwd();
    t_priority();
    t_reg_zero();
    t_wen_off();
    t_split();
    t_load();
    t_store();
    t_sweep();
    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule